// File: doc/BRIEF.md
# PHY Delay Register Access Bridge

This block gives a host a single 32-bit control/status word through which it can load and fetch the 8-bit delay settings of a small PHY delay-register file. The host never writes the PHY storage directly. It first places a target address and a data byte into the word while both strobe bits are clear. It then writes the same word again with a write or read strobe set, and polls until the acknowledge bit appears. The bridge carries out the PHY-side access after a fixed number of cycles and raises the acknowledge bit. The bit stays high until the host clears the strobe.

The delay file holds sixteen slots. Slots 0x00 through 0x08 hold per-speed-mode input delays. Slots 0x0B, 0x0C and 0x0D hold the clock, high-speed and strobe DLL delays. Every other address is a hole: an access to it completes its handshake, but the data goes nowhere. The whole file is also presented on a flat output bus that feeds the delay lines.

Top module: `phy_access_bridge`

## Requirements
- R1: After synchronous reset, the control word reads as all zeros, and every delay slot on `dly_flat` is zero.
- R2: Host writes store the address in bits 7:0, the write data in 15:8, the write strobe in bit 24 and the read strobe in bit 25. The read-data field (bits 23:16) and the acknowledge bit (bit 26) ignore host writes. Bits 31:27 always read zero.
- R3: The acknowledge bit becomes visible exactly ACK_DELAY clock cycles after the edge at which a strobe was stored. It never rises unless a strobe was set in the preceding cycle.
- R4: While the strobe stays set, acknowledge stays high. It drops one cycle after the edge at which the host clears both strobes.
- R5: A completed write handshake to a defined address (0x00–0x08, 0x0B, 0x0C, 0x0D) stores the data byte in that slot, at the same edge that raises acknowledge. Slot i drives `dly_flat[8*i+7:8*i]`.
- R6: A completed read handshake loads the addressed slot's value into the read-data field, at the same edge that raises acknowledge.
- R7: If both strobes are set, the bridge performs the write and skips the read. The read-data field keeps its previous value.
- R8: A write to an undefined address (0x09, 0x0A, 0x0E, 0x0F or any address of 0x10 and above) is acknowledged but changes no slot. A read of such an address returns zero.
- R9: The read-data field changes only when a read handshake completes, and holds its value at all other times.
- R10: If the strobe is cleared before acknowledge arrives, the access is abandoned: no slot changes and acknowledge stays low.
- R11: Loading the address and data with both strobes clear starts no PHY access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Host write enable for the control word |
| reg_wdata | input | 32 | Host write data for the control word |
| reg_rdata | output | 32 | Current value of the control word |
| dly_flat | output | NUM_ENTRIES*8 | All delay slots, slot i in bits 8*i+7:8*i |

## Verification
Several properties are checked on every clock cycle. Acknowledge always drops one cycle after both strobes are clear, and it never rises without a strobe having been set in the cycle before. Neither the read-data field nor any delay slot changes except on the cycle acknowledge rises. The hole slots stay at zero, and the top bits stay at zero. Some behaviours can only be shown by the bench's scenarios:
- the exact acknowledge latency;
- that data lands in the intended slot;
- write priority when both strobes are set;
- aborted handshakes;
- that an out-of-range address does not alias onto a real slot.

// File: rtl/phy_bridge_pkg.sv
package phy_bridge_pkg;

    localparam int FIELD_W   = 8;
    localparam int WORD_W    = 32;
    localparam int ADDR_LSB  = 0;
    localparam int WDATA_LSB = 8;
    localparam int RDATA_LSB = 16;
    localparam int WSTB_BIT  = 24;
    localparam int RSTB_BIT  = 25;
    localparam int ACK_BIT   = 26;

    typedef logic [FIELD_W-1:0] byte_t;

    typedef enum logic [1:0] {
        HS_IDLE = 2'd0,
        HS_WAIT = 2'd1,
        HS_DONE = 2'd2
    } hs_state_e;

    // Host-owned portion of the control word
    typedef struct packed {
        logic  rd_stb;
        logic  wr_stb;
        byte_t wdata;
        byte_t addr;
    } ctrl_t;

    // One PHY-side access, valid for a single cycle
    typedef struct packed {
        logic  valid;
        logic  is_write;
        byte_t addr;
        byte_t wdata;
    } phy_op_t;

    // Addresses backed by real delay storage
    function automatic logic addr_defined(input byte_t a);
        return (a <= 8'h08) || ((a >= 8'h0B) && (a <= 8'h0D));
    endfunction

endpackage

// File: rtl/phy_ctrl_reg.sv
module phy_ctrl_reg
    import phy_bridge_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wdata,
    output ctrl_t             ctrl
);

    // Read-only and reserved bits of the host word are dropped here
    logic unused_ro_bits;
    assign unused_ro_bits = ^{wdata[WORD_W-1:ACK_BIT], wdata[RDATA_LSB +: FIELD_W]};

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
        end else if (wr_en) begin
            ctrl.addr   <= wdata[ADDR_LSB  +: FIELD_W];
            ctrl.wdata  <= wdata[WDATA_LSB +: FIELD_W];
            ctrl.wr_stb <= wdata[WSTB_BIT];
            ctrl.rd_stb <= wdata[RSTB_BIT];
        end
    end

endmodule

// File: rtl/phy_hs_fsm.sv
module phy_hs_fsm
    import phy_bridge_pkg::*;
#(
    parameter int ACK_DELAY = 4
)(
    input  logic    clk,
    input  logic    rst,
    input  ctrl_t   ctrl,
    output logic    ack,
    output phy_op_t op
);

    localparam int EFF_DELAY = (ACK_DELAY < 2) ? 2 : ACK_DELAY;
    localparam int CNT_W     = $clog2(EFF_DELAY + 1);

    hs_state_e        state;
    logic [CNT_W-1:0] cnt;
    logic             req;
    logic             fire;

    assign req  = ctrl.wr_stb | ctrl.rd_stb;
    assign fire = (state == HS_WAIT) && req && (cnt == CNT_W'(EFF_DELAY - 1));

    // The write strobe wins when both are set
    always_comb begin
        op.valid    = fire;
        op.is_write = ctrl.wr_stb;
        op.addr     = ctrl.addr;
        op.wdata    = ctrl.wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= HS_IDLE;
            cnt   <= '0;
            ack   <= 1'b0;
        end else begin
            case (state)
                HS_IDLE: begin
                    if (req) begin
                        state <= HS_WAIT;
                        cnt   <= CNT_W'(1);
                    end
                end
                HS_WAIT: begin
                    if (!req) begin
                        state <= HS_IDLE;
                        cnt   <= '0;
                    end else if (fire) begin
                        state <= HS_DONE;
                        ack   <= 1'b1;
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                HS_DONE: begin
                    if (!req) begin
                        state <= HS_IDLE;
                        ack   <= 1'b0;
                        cnt   <= '0;
                    end
                end
                default: begin
                    state <= HS_IDLE;
                    ack   <= 1'b0;
                    cnt   <= '0;
                end
            endcase
        end
    end

endmodule

// File: rtl/phy_dly_file.sv
module phy_dly_file
    import phy_bridge_pkg::*;
#(
    parameter int NUM_ENTRIES = 16
)(
    input  logic                         clk,
    input  logic                         rst,
    input  phy_op_t                      op,
    output byte_t                        rd_val,
    output logic [NUM_ENTRIES*FIELD_W-1:0] dly_flat
);

    genvar gi;
    generate
        for (gi = 0; gi < NUM_ENTRIES; gi++) begin : g_slot
            if (addr_defined(FIELD_W'(gi))) begin : g_real
                byte_t slot_q;
                always_ff @(posedge clk) begin
                    if (rst) begin
                        slot_q <= '0;
                    end else if (op.valid && op.is_write && (op.addr == FIELD_W'(gi))) begin
                        slot_q <= op.wdata;
                    end
                end
                assign dly_flat[gi*FIELD_W +: FIELD_W] = slot_q;
            end else begin : g_hole
                assign dly_flat[gi*FIELD_W +: FIELD_W] = '0;
            end
        end
    endgenerate

    // Holes read as zero because their slices are tied low; out-of-range misses
    always_comb begin
        rd_val = '0;
        for (int i = 0; i < NUM_ENTRIES; i++) begin
            if (op.addr == FIELD_W'(i)) begin
                rd_val = dly_flat[i*FIELD_W +: FIELD_W];
            end
        end
    end

endmodule

// File: rtl/phy_access_bridge.sv
module phy_access_bridge
    import phy_bridge_pkg::*;
#(
    parameter int ACK_DELAY   = 4,
    parameter int NUM_ENTRIES = 16
)(
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           reg_wr_en,
    input  logic [31:0]                    reg_wdata,
    output logic [31:0]                    reg_rdata,
    output logic [NUM_ENTRIES*8-1:0]       dly_flat
);

    ctrl_t   ctrl;
    phy_op_t op;
    logic    ack;
    byte_t   rd_val;
    byte_t   rd_field_q;

    phy_ctrl_reg u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .wr_en (reg_wr_en),
        .wdata (reg_wdata),
        .ctrl  (ctrl)
    );

    phy_hs_fsm #(.ACK_DELAY(ACK_DELAY)) u_fsm (
        .clk  (clk),
        .rst  (rst),
        .ctrl (ctrl),
        .ack  (ack),
        .op   (op)
    );

    phy_dly_file #(.NUM_ENTRIES(NUM_ENTRIES)) u_file (
        .clk      (clk),
        .rst      (rst),
        .op       (op),
        .rd_val   (rd_val),
        .dly_flat (dly_flat)
    );

    // Read-data field captures only on a completed read
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_field_q <= '0;
        end else if (op.valid && !op.is_write) begin
            rd_field_q <= rd_val;
        end
    end

    always_comb begin
        reg_rdata                              = '0;
        reg_rdata[ADDR_LSB  +: FIELD_W]        = ctrl.addr;
        reg_rdata[WDATA_LSB +: FIELD_W]        = ctrl.wdata;
        reg_rdata[RDATA_LSB +: FIELD_W]        = rd_field_q;
        reg_rdata[WSTB_BIT]                    = ctrl.wr_stb;
        reg_rdata[RSTB_BIT]                    = ctrl.rd_stb;
        reg_rdata[ACK_BIT]                     = ack;
    end

endmodule

// File: rtl/phy_access_bridge_chk.sv
module phy_access_bridge_chk
    import phy_bridge_pkg::*;
#(
    parameter int NUM_ENTRIES = 16
)(
    input logic                       clk,
    input logic                       rst,
    input logic                       ack,
    input logic                       wr_stb,
    input logic                       rd_stb,
    input logic [7:0]                 rd_field,
    input logic [4:0]                 top_bits,
    input logic [NUM_ENTRIES*8-1:0]   dly_flat
);

    logic hole_nonzero;
    always_comb begin
        hole_nonzero = 1'b0;
        for (int i = 0; i < NUM_ENTRIES; i++) begin
            if (!addr_defined(8'(i)) && (dly_flat[i*8 +: 8] != 8'h00)) begin
                hole_nonzero = 1'b1;
            end
        end
    end

    a_r4_ack_release: assert property (@(posedge clk) disable iff (rst)
        (!wr_stb && !rd_stb) |=> !ack);

    a_r3_ack_needs_strobe: assert property (@(posedge clk) disable iff (rst)
        $rose(ack) |-> $past(wr_stb || rd_stb));

    a_r9_rdata_hold: assert property (@(posedge clk) disable iff (rst)
        !$rose(ack) |-> $stable(rd_field));

    a_r5_slots_move_at_ack: assert property (@(posedge clk) disable iff (rst)
        !$rose(ack) |-> $stable(dly_flat));

    a_r8_holes_zero: assert property (@(posedge clk) disable iff (rst)
        !hole_nonzero);

    a_r2_top_bits_zero: assert property (@(posedge clk) disable iff (rst)
        top_bits == 5'b0);

endmodule

bind phy_access_bridge phy_access_bridge_chk #(.NUM_ENTRIES(NUM_ENTRIES)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .ack      (reg_rdata[26]),
    .wr_stb   (reg_rdata[24]),
    .rd_stb   (reg_rdata[25]),
    .rd_field (reg_rdata[23:16]),
    .top_bits (reg_rdata[31:27]),
    .dly_flat (dly_flat)
);

// File: tb/tb_phy_access_bridge.sv
`timescale 1ns/1ps
module tb_phy_access_bridge;

    localparam int ACK_DELAY   = 4;
    localparam int NUM_ENTRIES = 16;

    logic                         clk = 1'b0;
    logic                         rst;
    logic                         reg_wr_en;
    logic [31:0]                  reg_wdata;
    logic [31:0]                  reg_rdata;
    logic [NUM_ENTRIES*8-1:0]     dly_flat;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;
    logic [7:0] exp_rd = 8'h00;

    always #2 clk = ~clk;

    phy_access_bridge #(.ACK_DELAY(ACK_DELAY), .NUM_ENTRIES(NUM_ENTRIES)) dut (
        .clk       (clk),
        .rst       (rst),
        .reg_wr_en (reg_wr_en),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .dly_flat  (dly_flat)
    );

    typedef struct packed {
        logic       wr;
        logic [7:0] a;
        logic [7:0] d;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 8'h00, 8'h11}, '{1'b1, 8'h08, 8'h88}, '{1'b1, 8'h0B, 8'hB5},
        '{1'b1, 8'h0C, 8'hC3}, '{1'b1, 8'h0D, 8'h7E}, '{1'b1, 8'h09, 8'h99},
        '{1'b1, 8'h0F, 8'hF0}, '{1'b1, 8'h20, 8'h55},
        '{1'b0, 8'h00, 8'h11}, '{1'b0, 8'h08, 8'h88}, '{1'b0, 8'h0B, 8'hB5},
        '{1'b0, 8'h0C, 8'hC3}, '{1'b0, 8'h0D, 8'h7E}, '{1'b0, 8'h09, 8'h00},
        '{1'b0, 8'h0F, 8'h00}, '{1'b0, 8'h20, 8'h00},
        '{1'b1, 8'h04, 8'h3C}, '{1'b0, 8'h04, 8'h3C}
    };

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // Called at a falling edge; returns at the next falling edge
    task automatic host_write(input logic [31:0] v);
        reg_wr_en = 1'b1;
        reg_wdata = v;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    function automatic logic [31:0] word(input logic rd, input logic wr, input logic [7:0] d, input logic [7:0] a);
        return {6'b0, rd, wr, 8'h00, d, a};
    endfunction

    task automatic handshake(input logic rd, input logic wr, input logic [7:0] a, input logic [7:0] d);
        int n;
        host_write(word(1'b0, 1'b0, d, a));
        host_write(word(rd, wr, d, a));
        n = 0;
        while (!reg_rdata[26] && n < 50) begin
            @(negedge clk);
            n++;
        end
        check(n == ACK_DELAY, "R3 ack latency", n, ACK_DELAY);
        repeat (3) @(negedge clk);
        check(reg_rdata[26] == 1'b1, "R4 ack held while strobe set", reg_rdata[26], 1);
        host_write(word(1'b0, 1'b0, d, a));
        check(reg_rdata[26] == 1'b1, "R4 ack one cycle after clear", reg_rdata[26], 1);
        @(negedge clk);
        check(reg_rdata[26] == 1'b0, "R4 ack dropped", reg_rdata[26], 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst       = 1'b1;
        reg_wr_en = 1'b0;
        reg_wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        check(reg_rdata == 32'h0, "R1 word after reset", reg_rdata, 0);
        check(dly_flat == '0, "R1 slots after reset", dly_flat[31:0], 0);

        // Table walk: R5, R6, R8
        for (int k = 0; k < NV; k++) begin
            if (VECS[k].wr) begin
                handshake(1'b0, 1'b1, VECS[k].a, VECS[k].d);
            end else begin
                handshake(1'b1, 1'b0, VECS[k].a, 8'h00);
                exp_rd = VECS[k].d;
                check(reg_rdata[23:16] == exp_rd, "R6/R8 read data", reg_rdata[23:16], exp_rd);
            end
        end

        // R5: slots visible on the delay bus
        check(dly_flat[8*0  +: 8] == 8'h11, "R5 slot 0x00 (alias 0x20 ignored)", dly_flat[8*0 +: 8], 8'h11);
        check(dly_flat[8*12 +: 8] == 8'hC3, "R5 slot 0x0C", dly_flat[8*12 +: 8], 8'hC3);
        check(dly_flat[8*4  +: 8] == 8'h3C, "R5 slot 0x04", dly_flat[8*4 +: 8], 8'h3C);
        check(dly_flat[8*9  +: 8] == 8'h00, "R8 hole 0x09 stays zero", dly_flat[8*9 +: 8], 0);

        // R2 and R11: layout, read-only bits, no access without strobe
        host_write(32'hFCFF_5AA5);
        check(reg_rdata == {8'h00, exp_rd, 16'h5AA5}, "R2 field layout", reg_rdata, {8'h00, exp_rd, 16'h5AA5});
        host_write(32'h0000_A50A);
        repeat (ACK_DELAY + 2) @(negedge clk);
        check(reg_rdata[26] == 1'b0, "R11 no ack without strobe", reg_rdata[26], 0);
        check(dly_flat[8*10 +: 8] == 8'h00 && dly_flat[8*5 +: 8] == 8'h00, "R11 no slot change", dly_flat[8*10 +: 8], 0);
        host_write(word(1'b1, 1'b1, 8'h00, 8'h00));
        check(reg_rdata[25:24] == 2'b11, "R2 strobe bits", reg_rdata[25:24], 2'b11);
        host_write(32'h0);
        repeat (ACK_DELAY + 2) @(negedge clk);

        // R7: both strobes, write wins, read field holds (R9)
        handshake(1'b1, 1'b1, 8'h02, 8'h6D);
        check(reg_rdata[23:16] == exp_rd, "R7/R9 read field held", reg_rdata[23:16], exp_rd);
        check(dly_flat[8*2 +: 8] == 8'h6D, "R7 write performed", dly_flat[8*2 +: 8], 8'h6D);
        handshake(1'b1, 1'b0, 8'h02, 8'h00);
        exp_rd = 8'h6D;
        check(reg_rdata[23:16] == exp_rd, "R6 read back 0x02", reg_rdata[23:16], exp_rd);

        // R10: abandoned handshake
        host_write(word(1'b0, 1'b0, 8'h77, 8'h03));
        host_write(word(1'b0, 1'b1, 8'h77, 8'h03));
        host_write(word(1'b0, 1'b0, 8'h77, 8'h03));
        for (int c = 0; c < ACK_DELAY + 3; c++) begin
            check(reg_rdata[26] == 1'b0, "R10 no ack after abort", reg_rdata[26], 0);
            @(negedge clk);
        end
        check(dly_flat[8*3 +: 8] == 8'h00, "R10 slot unchanged", dly_flat[8*3 +: 8], 0);
        check(reg_rdata[23:16] == exp_rd, "R9 read field stable", reg_rdata[23:16], exp_rd);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule